// File: doc/BRIEF.md
# Multi-channel PWM timer bank

This block is a bank of four down-counting timers. Each timer can drive one pulse-width-modulated pin and one interrupt line. Software reaches it over a plain memory-mapped register port with address, write data, write enable, read enable and registered read data. Each timer has a running counter, a reload value and two compare values. One shared control word holds a 4-bit field for each timer.

A timer counts down from its reload value to zero. On the next tick it reloads, so one period lasts reload+1 ticks. The pin is high while the count is above the first compare value. Software therefore sets that compare to reload minus the wanted high time. Writing the counter register loads the running count at once, which lets software start a fresh period.

A tick is either every clock or each clock on which an external tick-enable input is high. Each timer has a three-state machine:

- **CH_OFF**: the timer is disabled.
- **CH_RUN**: the timer is counting.
- **CH_HOLD**: the timer is enabled but its setting is invalid, so the counter is frozen and the pin is held low.

The state machine moves between these states as follows:

- **OFF→RUN** is taken when enable is set and the setting is valid.
- **OFF→HOLD** is taken when enable is set and the setting is invalid.
- **RUN→HOLD** is taken when the setting becomes invalid.
- **HOLD→RUN** is taken when the setting becomes valid again.
- **RUN→OFF** and **HOLD→OFF** are taken whenever enable is cleared.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads zero, every channel is in CH_OFF, and all pwm_o and irq_o bits are 0.
- R2: Channel k (k = 0..3) has a block of registers at byte address 0x50 + 0x10*k. Offset +0x0 is the counter, +0x4 the reload, +0x8 compare A and +0xC compare B. Reload, compare A and compare B read back the value written. The counter reads its live value.
- R3: The control word is at byte address 0x30. Channel k owns bits [16+4k +: 4]. Within that field, bit 0 is enable, bit 1 is tick select, bit 2 is interrupt enable and bit 3 is pin enable. Bits 15..0 read as 0. A field affects only its own channel.
- R4: While running, the counter steps down by one per tick. On a tick where it is 0 it loads the reload value, so a period lasts reload+1 ticks and the pin rises once per period.
- R5: The pin is high exactly while the count is greater than compare A, which gives reload − compareA high ticks per period.
- R6: A write to the counter register replaces the running count on that clock edge, taking priority over counting.
- R7: With enable clear, the counter is frozen. With enable or pin enable clear, the pin is low.
- R8: With tick select 0 the counter steps on every clock. With tick select 1 it steps only on clocks where ext_tick is 1.
- R9: irq_o[k] pulses for one cycle, one edge after the count steps down onto 0 or onto compare B, but only when interrupt enable is set.
- R10: A reload or compare A of 0 is invalid. The channel then stays in CH_HOLD with its counter frozen and its pin low.
- R11: Reads of any address other than 0x30 and the word-aligned channel registers return 0. Read data appears on bus_rdata one edge after bus_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ext_tick | input | 1 | External tick enable for channels with tick select 1 |
| pwm_o | output | 4 | PWM pins, bit k for channel k |
| irq_o | output | 4 | Interrupt pulses, bit k for channel k |

## Verification
Read data is captured on the edge where bus_re is high. It holds the counter value from before that edge's step, so a read issued right after a counter write returns exactly the written value, and each following edge removes one. The pin follows the count without delay, so duty and period are checked by counting high samples and rising edges over a window of whole periods after a settling delay. Window counts do not depend on phase. Interrupts arrive one edge after the step, so they are counted over whole periods as well. Control changes reach the state machine one edge late, and the bench always waits at least two cycles before sampling after one.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Per-channel control field, LSB first: enable, tick select, irq enable, pin enable
    typedef struct packed {
        logic pin_en;
        logic irq_en;
        logic tick_sel;
        logic enable;
    } ch_ctrl_t;

    localparam int CTRL_FIELD_W = 4;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2
    } ch_state_e;

    // register index inside a channel block (address bits [3:2])
    localparam logic [1:0] REG_COUNT = 2'd0;
    localparam logic [1:0] REG_RELOAD = 2'd1;
    localparam logic [1:0] REG_CMPA = 2'd2;
    localparam logic [1:0] REG_CMPB = 2'd3;

endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFS  = 'h30,
    parameter int CH_BASE   = 'h50,
    parameter int CH_STRIDE = 'h10,
    localparam int FIELD_BITS = NUM_CH * CTRL_FIELD_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic                                   we,
    input  logic [FIELD_BITS-1:0]                  ctrl_wdata,
    output logic [NUM_CH-1:0][CTRL_FIELD_W-1:0]    ctrl_q,
    output logic                                   hit_ctrl,
    output logic [NUM_CH-1:0]                      hit_ch,
    output logic [1:0]                             reg_sel,
    output logic [NUM_CH-1:0]                      wr_cnt,
    output logic [NUM_CH-1:0]                      wr_rld,
    output logic [NUM_CH-1:0]                      wr_cmpa,
    output logic [NUM_CH-1:0]                      wr_cmpb
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

    assign hit_ctrl = (addr == CTRL_ADDR);
    assign reg_sel  = addr[3:2];

    // channel blocks are 16-byte aligned: compare upper bits, require word alignment
    for (genvar k = 0; k < NUM_CH; k++) begin : g_hit
        localparam logic [ADDR_W-1:0] BLK = ADDR_W'(CH_BASE + k * CH_STRIDE);
        assign hit_ch[k]  = (addr[ADDR_W-1:4] == BLK[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
        assign wr_cnt[k]  = we && hit_ch[k] && (reg_sel == REG_COUNT);
        assign wr_rld[k]  = we && hit_ch[k] && (reg_sel == REG_RELOAD);
        assign wr_cmpa[k] = we && hit_ch[k] && (reg_sel == REG_CMPA);
        assign wr_cmpb[k] = we && hit_ch[k] && (reg_sel == REG_CMPB);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && hit_ctrl) begin
            ctrl_q <= ctrl_wdata;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_ctrl_t         ctrl,
    input  logic             ext_tick,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_cmpa,
    input  logic             wr_cmpb,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CNT_W-1:0] cmpa_o,
    output logic [CNT_W-1:0] cmpb_o,
    output logic             pwm_o,
    output logic             irq_o
);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, rld_q, cmpa_q, cmpb_q;
    logic [CNT_W-1:0] cnt_dn;
    logic             cfg_ok, at_zero, step, irq_q;

    assign cfg_ok  = (rld_q != '0) && (cmpa_q != '0);
    assign at_zero = (cnt_q == '0);
    assign cnt_dn  = cnt_q - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (ctrl.enable) st_d = cfg_ok ? CH_RUN : CH_HOLD;
            end
            CH_RUN: begin
                if (!ctrl.enable)  st_d = CH_OFF;
                else if (!cfg_ok)  st_d = CH_HOLD;
            end
            CH_HOLD: begin
                if (!ctrl.enable)  st_d = CH_OFF;
                else if (cfg_ok)   st_d = CH_RUN;
            end
            default: st_d = CH_OFF;
        endcase
    end

    // state outputs: count step and pin level
    always_comb begin
        step  = 1'b0;
        pwm_o = 1'b0;
        unique case (st_q)
            CH_RUN: begin
                step  = ctrl.enable && cfg_ok && (ctrl.tick_sel ? ext_tick : 1'b1);
                pwm_o = ctrl.enable && ctrl.pin_en && cfg_ok && (cnt_q > cmpa_q);
            end
            CH_OFF, CH_HOLD: begin
                step  = 1'b0;
                pwm_o = 1'b0;
            end
            default: begin
                step  = 1'b0;
                pwm_o = 1'b0;
            end
        endcase
    end

    // settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q  <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else begin
            if (wr_rld)  rld_q  <= wdata;
            if (wr_cmpa) cmpa_q <= wdata;
            if (wr_cmpb) cmpb_q <= wdata;
        end
    end

    // counter: bus load wins over stepping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (step) begin
            cnt_q <= at_zero ? rld_q : cnt_dn;
        end
    end

    // interrupt pulse on arrival at zero or compare B
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= ctrl.irq_en && step && !at_zero && !wr_cnt && !wr_cmpb
                     && ((cnt_dn == '0) || (cnt_dn == cmpb_q));
        end
    end

    assign irq_o  = irq_q;
    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign cmpa_o = cmpa_q;
    assign cmpb_o = cmpb_q;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFS  = 'h30,
    parameter int CTRL_LSB  = 16,
    parameter int CH_BASE   = 'h50,
    parameter int CH_STRIDE = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int FIELD_BITS = NUM_CH * CTRL_FIELD_W;

    logic [NUM_CH-1:0][CTRL_FIELD_W-1:0] ctrl_q;
    logic                                hit_ctrl;
    logic [NUM_CH-1:0]                   hit_ch;
    logic [1:0]                          reg_sel;
    logic [NUM_CH-1:0]                   wr_cnt, wr_rld, wr_cmpa, wr_cmpb;
    logic [NUM_CH-1:0][DATA_W-1:0]       cnt_all, rld_all, cmpa_all, cmpb_all;
    logic [DATA_W-1:0]                   rd_val;

    pwm_bus_decode #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .CH_BASE  (CH_BASE),
        .CH_STRIDE(CH_STRIDE)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .ctrl_wdata(bus_wdata[CTRL_LSB +: FIELD_BITS]),
        .ctrl_q    (ctrl_q),
        .hit_ctrl  (hit_ctrl),
        .hit_ch    (hit_ch),
        .reg_sel   (reg_sel),
        .wr_cnt    (wr_cnt),
        .wr_rld    (wr_rld),
        .wr_cmpa   (wr_cmpa),
        .wr_cmpb   (wr_cmpb)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwm_chan #(.CNT_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl    (ch_ctrl_t'(ctrl_q[k])),
            .ext_tick(ext_tick),
            .wdata   (bus_wdata),
            .wr_cnt  (wr_cnt[k]),
            .wr_rld  (wr_rld[k]),
            .wr_cmpa (wr_cmpa[k]),
            .wr_cmpb (wr_cmpb[k]),
            .cnt_o   (cnt_all[k]),
            .rld_o   (rld_all[k]),
            .cmpa_o  (cmpa_all[k]),
            .cmpb_o  (cmpb_all[k]),
            .pwm_o   (pwm_o[k]),
            .irq_o   (irq_o[k])
        );
    end

    // read mux: unmapped addresses give zero
    always_comb begin
        rd_val = '0;
        if (hit_ctrl) begin
            rd_val[CTRL_LSB +: FIELD_BITS] = ctrl_q;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (hit_ch[k]) begin
                unique case (reg_sel)
                    REG_COUNT:  rd_val = cnt_all[k];
                    REG_RELOAD: rd_val = rld_all[k];
                    REG_CMPA:   rd_val = cmpa_all[k];
                    REG_CMPB:   rd_val = cmpb_all[k];
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFS  = 'h30,
    parameter int CH_BASE   = 'h50,
    parameter int CH_STRIDE = 'h10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_re,
    input logic                         bus_we,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic                         ext_tick,
    input logic [NUM_CH-1:0]            pwm_o,
    input logic [NUM_CH-1:0]            irq_o,
    input logic [NUM_CH-1:0][3:0]       ctrl_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_all,
    input logic [NUM_CH-1:0][DATA_W-1:0] rld_all,
    input logic [NUM_CH-1:0][DATA_W-1:0] cmpa_all,
    input logic [NUM_CH-1:0][DATA_W-1:0] cmpb_all
);

    localparam int CH_END = CH_BASE + NUM_CH * CH_STRIDE;

    logic mapped;
    assign mapped = (int'(bus_addr) == CTRL_OFS) ||
                    ((int'(bus_addr) >= CH_BASE) && (int'(bus_addr) < CH_END) &&
                     (bus_addr[1:0] == 2'b00));

    // R11: unmapped reads return zero on the next edge
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !mapped) |=> (bus_rdata == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // R7: pin low whenever enable or pin enable is clear
        a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[k][0] || !ctrl_q[k][3]) |-> !pwm_o[k]);

        // R5: a high pin implies count above compare A
        a_r5_level: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_o[k] |-> (cnt_all[k] > cmpa_all[k]));

        // R10: invalid setting keeps pin low
        a_r10_invalid_low: assert property (@(posedge clk) disable iff (!rst_n)
            ((rld_all[k] == '0) || (cmpa_all[k] == '0)) |-> !pwm_o[k]);

        // R9: an interrupt only follows arrival at zero or compare B
        a_r9_irq_event: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] |-> ((cnt_all[k] == '0) || (cnt_all[k] == cmpb_all[k])));

        // R9: an interrupt needs interrupt enable on the edge that raised it
        a_r9_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[k]) |-> $past(ctrl_q[k][2]));

        // R8: external tick low freezes a tick-select channel
        a_r8_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[k][1] && !ext_tick && !bus_we) |=> $stable(cnt_all[k]));
    end

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .CH_BASE  (CH_BASE),
    .CH_STRIDE(CH_STRIDE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_re   (bus_re),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .ext_tick (ext_tick),
    .pwm_o    (pwm_o),
    .irq_o    (irq_o),
    .ctrl_q   (ctrl_q),
    .cnt_all  (cnt_all),
    .rld_all  (rld_all),
    .cmpa_all (cmpa_all),
    .cmpb_all (cmpb_all)
);

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;

    localparam logic [31:0] F_EN = 32'h1;
    localparam logic [31:0] F_TS = 32'h2;
    localparam logic [31:0] F_IE = 32'h4;
    localparam logic [31:0] F_PE = 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic [3:0]  pwm_o;
    logic [3:0]  irq_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwm_timer_bank u_pwm_timer_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata),
        .ext_tick (ext_tick),
        .pwm_o    (pwm_o),
        .irq_o    (irq_o)
    );

    function automatic logic [7:0] ch_addr(int k, int r);
        return 8'(8'h50 + 16 * k + 4 * r);
    endfunction

    function automatic logic [31:0] fld(int k, logic [31:0] f);
        return f << (16 + 4 * k);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)",
                     req, act, act, exp, exp);
        end
    endtask

    // called just after a negedge; returns just after a negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic measure(input int k, input int n, output int hi, output int rises,
                           output int irqs);
        logic prev;
        hi = 0; rises = 0; irqs = 0;
        prev = pwm_o[k];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[k]) hi++;
            if (pwm_o[k] && !prev) rises++;
            if (irq_o[k]) irqs++;
            prev = pwm_o[k];
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int hi, rs, iq;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(pwm_o == 4'b0, "R1 pwm after reset", 32'(pwm_o), 0);
        check(irq_o == 4'b0, "R1 irq after reset", 32'(irq_o), 0);
        rd(8'h30, v);
        check(v == 0, "R1 ctrl after reset", v, 0);
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) begin
                rd(ch_addr(k, r), v);
                check(v == 0, "R1 channel reg after reset", v, 0);
            end
        end

        // R2: readback with channels disabled (counter frozen, R7)
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) wr(ch_addr(k, r), 32'h1000 * (r + 1) + 32'(k));
        end
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) begin
                rd(ch_addr(k, r), v);
                check(v == 32'h1000 * (r + 1) + 32'(k), "R2 readback", v,
                      32'h1000 * (r + 1) + 32'(k));
            end
        end

        // R3: control word width and reserved bits
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, v);
        check(v == 32'hFFFF_0000, "R3 ctrl readback", v, 32'hFFFF_0000);
        wr(8'h30, 32'h0);

        // R11: unmapped offsets, each after a nonzero read
        foreach (v2[i]) begin end
        begin
            logic [7:0] bad [5] = '{8'h00, 8'h34, 8'h4C, 8'h90, 8'h51};
            for (int i = 0; i < 5; i++) begin
                rd(ch_addr(0, 1), v);
                rd(bad[i], v);
                check(v == 0, "R11 unmapped read", v, 0);
            end
        end

        // R4/R5 sweep: every channel, reload 2..7, every valid high time
        for (int k = 0; k < 4; k++) begin
            for (int r = 2; r <= 7; r++) begin
                for (int h = 1; h < r; h++) begin
                    wr(8'h30, 0);
                    wr(ch_addr(k, 1), 32'(r));
                    wr(ch_addr(k, 2), 32'(r - h));
                    wr(ch_addr(k, 0), 32'(r));
                    wr(8'h30, fld(k, F_EN | F_PE));
                    repeat (2 * (r + 1)) @(negedge clk);
                    measure(k, 3 * (r + 1), hi, rs, iq);
                    check(hi == 3 * h, "R5 high ticks per 3 periods", 32'(hi), 32'(3 * h));
                    check(rs == 3, "R4 one rise per period", 32'(rs), 3);
                end
            end
        end

        // R3: field isolation, only channel 1 enabled
        for (int k = 0; k < 4; k++) begin
            wr(ch_addr(k, 1), 6);
            wr(ch_addr(k, 2), 3);
            wr(ch_addr(k, 0), 6);
        end
        wr(8'h30, fld(1, F_EN | F_PE));
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            measure(k, 14, hi, rs, iq);
            check(hi == ((k == 1) ? 6 : 0), "R3 field selects own channel", 32'(hi),
                  32'((k == 1) ? 6 : 0));
        end

        // R7: pin enable clear -> pin low, counter still runs
        wr(8'h30, fld(1, F_EN));
        repeat (2) @(negedge clk);
        measure(1, 14, hi, rs, iq);
        check(hi == 0, "R7 pin low without pin enable", 32'(hi), 0);
        rd(ch_addr(1, 0), v);
        repeat (3) @(negedge clk);
        rd(ch_addr(1, 0), v2);
        check(v != v2, "R7 counter runs with enable", v2, v);
        // R7: enable clear -> counter frozen
        wr(8'h30, 0);
        repeat (2) @(negedge clk);
        rd(ch_addr(1, 0), v);
        repeat (5) @(negedge clk);
        rd(ch_addr(1, 0), v2);
        check(v == v2, "R7 counter frozen when disabled", v2, v);

        // R6 / R4: counter load and reload from zero
        wr(ch_addr(1, 1), 100);
        wr(ch_addr(1, 2), 50);
        wr(8'h30, fld(1, F_EN));
        repeat (3) @(negedge clk);
        wr(ch_addr(1, 0), 50);
        rd(ch_addr(1, 0), v);
        check(v == 50, "R6 counter load", v, 50);
        rd(ch_addr(1, 0), v);
        check(v == 49, "R4 decrement after load", v, 49);
        wr(ch_addr(1, 0), 0);
        rd(ch_addr(1, 0), v);
        check(v == 0, "R6 counter load zero", v, 0);
        rd(ch_addr(1, 0), v);
        check(v == 100, "R4 reload after zero", v, 100);

        // R8: tick select on channel 2
        wr(8'h30, 0);
        wr(ch_addr(2, 1), 1000);
        wr(ch_addr(2, 2), 10);
        wr(ch_addr(2, 0), 1000);
        wr(8'h30, fld(2, F_EN | F_TS));
        repeat (3) @(negedge clk);
        rd(ch_addr(2, 0), v);
        repeat (6) @(negedge clk);
        rd(ch_addr(2, 0), v2);
        check(v == 1000 && v2 == 1000, "R8 frozen with ext_tick low", v2, 1000);
        for (int i = 0; i < 20; i++) begin
            ext_tick = (i % 2 == 0);
            @(negedge clk);
        end
        ext_tick = 1'b0;
        rd(ch_addr(2, 0), v2);
        check(v2 == 990, "R8 one step per external tick", v2, 990);

        // R9: interrupts on channel 0 with reload 4, compare B 2
        wr(8'h30, 0);
        wr(ch_addr(0, 1), 4);
        wr(ch_addr(0, 2), 2);
        wr(ch_addr(0, 3), 2);
        wr(ch_addr(0, 0), 4);
        wr(8'h30, fld(0, F_EN | F_PE | F_IE));
        repeat (10) @(negedge clk);
        measure(0, 25, hi, rs, iq);
        check(iq == 10, "R9 two pulses per period", 32'(iq), 10);
        wr(8'h30, fld(0, F_EN | F_PE));
        repeat (3) @(negedge clk);
        measure(0, 25, hi, rs, iq);
        check(iq == 0, "R9 no pulse without irq enable", 32'(iq), 0);
        check(hi == 10, "R5 pin still toggles", 32'(hi), 10);

        // R10: invalid settings on channel 3
        wr(8'h30, 0);
        wr(ch_addr(3, 1), 5);
        wr(ch_addr(3, 2), 0);
        wr(ch_addr(3, 0), 5);
        wr(8'h30, fld(3, F_EN | F_PE));
        repeat (3) @(negedge clk);
        measure(3, 18, hi, rs, iq);
        check(hi == 0, "R10 compare A zero keeps pin low", 32'(hi), 0);
        rd(ch_addr(3, 0), v);
        check(v == 5, "R10 counter frozen in hold", v, 5);
        wr(ch_addr(3, 1), 0);
        wr(ch_addr(3, 2), 2);
        repeat (3) @(negedge clk);
        measure(3, 18, hi, rs, iq);
        check(hi == 0, "R10 reload zero keeps pin low", 32'(hi), 0);
        wr(ch_addr(3, 1), 5);
        repeat (14) @(negedge clk);
        measure(3, 18, hi, rs, iq);
        check(hi == 9, "R10 recovers once valid", 32'(hi), 9);

        summary();
        $finish;
    end

endmodule